// File: doc/BRIEF.md
# Dual-Width Accumulator ALU

This block is the arithmetic and logic unit of an accumulator processor that runs either on a byte or on a 16-bit word. The width is chosen at run time from two status inputs: an emulation bit and a memory-width mode bit. The unit takes an operation code, the accumulator, a memory operand, the incoming carry and a flag that marks immediate addressing. One cycle later it presents a result, a write enable for that result, and a new value for each of the sign (N), overflow (V), zero (Z) and carry (C) flags. Each flag has its own update mask, so the status register only takes the flags the operation owns.

The operations are add and subtract with carry, AND, OR, XOR, compare, bit test, shift left, shift right, rotate left, rotate right, increment, decrement, test-and-set, test-and-reset and a plain load pass. Shifts, rotates, increment, decrement and the load pass act on the operand input; the caller routes the accumulator there when the target is the accumulator. Decimal arithmetic, operand fetch and cycle timing are outside the block.

Top module: `dwalu_top`

## Requirements
- R1: Byte width is used when `emu_bit` is 1, or when `emu_bit` is 0 and `wmode_bit` is 1; word width only when both are 0. Sign is bit 7 in byte width and bit 15 in word width, and carry is taken out of the same top bit.
- R2: In byte width, bits 15..8 of `result` equal bits 15..8 of `acc`; only the low byte carries the computed value.
- R3: Add (op 0) gives acc + opnd + carry_in on the active width, sets C to the carry out and V when both inputs share a sign that the result does not, updates N, V, Z, C and writes the result.
- R4: Subtract (op 1) gives acc - opnd - (1 - carry_in); C is 1 when no borrow occurred, V is the overflow of acc plus the inverted operand; it updates N, V, Z, C and writes the result.
- R5: Compare (op 5) never writes a result, leaves V alone, and updates N, Z and C, with C set when acc is greater than or equal to opnd, unsigned.
- R6: AND (2), OR (3), XOR (4), increment (11), decrement (12) and load pass (15, result = opnd) write the result and update only N and Z.
- R7: Shift left (7) moves 0 into bit 0 and the old top bit into C; N, Z and C are updated and the result is written.
- R8: Shift right (8) moves 0 into the top bit and the old bit 0 into C, and always updates N to 0; Z and C are updated too.
- R9: Rotate left (9) moves carry_in into bit 0 and the old top bit into C; rotate right (10) moves carry_in into the top bit and the old bit 0 into C; both update N, Z and C.
- R10: Bit test (6) with `imm_mode` 1 updates only Z (set when acc AND opnd is zero on the active width) and writes nothing.
- R11: Bit test with `imm_mode` 0 updates N and V from the operand's top two bits of the active width (7 and 6, or 15 and 14) and Z from acc AND opnd; it writes nothing.
- R12: Test-and-set (13) writes acc OR opnd, test-and-reset (14) writes (NOT acc) AND opnd; both update only Z, from acc AND opnd.
- R13: Outputs are registered: a request with `in_valid` 1 is presented one cycle later with `out_valid` 1; without a request, and during reset, `out_valid`, `result_we` and every update mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present this cycle |
| emu_bit | input | 1 | Emulation status bit, forces byte width when 1 |
| wmode_bit | input | 1 | Memory-width mode bit, byte width when 1 |
| op | input | 4 | Operation code |
| imm_mode | input | 1 | Operand comes from immediate addressing |
| acc | input | 16 | Accumulator value |
| opnd | input | 16 | Memory operand |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Outputs hold a result this cycle |
| result | output | 16 | Result value |
| result_we | output | 1 | Result is to be written back |
| n_val | output | 1 | New sign flag |
| n_upd | output | 1 | Sign flag is to be updated |
| v_val | output | 1 | New overflow flag |
| v_upd | output | 1 | Overflow flag is to be updated |
| z_val | output | 1 | New zero flag |
| z_upd | output | 1 | Zero flag is to be updated |
| c_val | output | 1 | New carry flag |
| c_upd | output | 1 | Carry flag is to be updated |

## Verification
The width switch and carry generation meet in the same cycle whenever an add or a shift carries across bit 7: in byte width that carry must land in C and must not reach bit 8, while in word width it must ripple into bit 8 and leave C clear. The bench drives the same operand pair, such as 0x00FF plus 0x0001, back to back under all three combinations of the two width bits and judges the result, the kept high byte and the C and V flags against values worked out by hand and by an independent model of the requirements.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_CMP  = 4'd5,
        OP_BIT  = 4'd6,
        OP_SHL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ROR  = 4'd10,
        OP_INC  = 4'd11,
        OP_DEC  = 4'd12,
        OP_TSET = 4'd13,
        OP_TCLR = 4'd14,
        OP_PASS = 4'd15
    } alu_op_e;

    // one bit per status flag, used both for values and for update masks
    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

    function automatic logic width_is_byte(input logic emu, input logic wmode);
        return emu | wmode;
    endfunction

    function automatic logic op_writes(input alu_op_e op);
        return !(op == OP_CMP || op == OP_BIT);
    endfunction

    function automatic flags_t flag_mask(input alu_op_e op, input logic imm);
        flags_t m;
        m = '0;
        unique case (op)
            OP_ADD, OP_SUB:                    m = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
            OP_CMP, OP_SHL, OP_SHR,
            OP_ROL, OP_ROR:                    m = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
            OP_AND, OP_OR, OP_XOR,
            OP_INC, OP_DEC, OP_PASS:           m = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
            OP_BIT:                            m = '{n: !imm, v: !imm, z: 1'b1, c: 1'b0};
            OP_TSET, OP_TCLR:                  m = '{n: 1'b0, v: 1'b0, z: 1'b1, c: 1'b0};
            default:                           m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dwalu_addsub.sv
module dwalu_addsub #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              invert_b,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   full_sum;
    logic [HALF_W:0]   half_sum;

    always_comb begin
        b_eff    = invert_b ? ~b : b;
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
        half_sum = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
        if (byte_mode) begin
            sum  = {{(DATA_W-HALF_W){1'b0}}, half_sum[HALF_W-1:0]};
            cout = half_sum[HALF_W];
            ovf  = (a[HALF_W-1] == b_eff[HALF_W-1]) && (half_sum[HALF_W-1] != a[HALF_W-1]);
        end else begin
            sum  = full_sum[DATA_W-1:0];
            cout = full_sum[DATA_W];
            ovf  = (a[DATA_W-1] == b_eff[DATA_W-1]) && (full_sum[DATA_W-1] != a[DATA_W-1]);
        end
    end
endmodule

// File: rtl/dwalu_bitops.sv
module dwalu_bitops
    import dwalu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] res,
    output logic              shift_out,
    output logic              and_zero,
    output logic              opnd_top,
    output logic              opnd_next
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    localparam logic [DATA_W-1:0] BYTE_TOP = DATA_W'(1) << (HALF_W - 1);
    localparam logic [DATA_W-1:0] WORD_TOP = DATA_W'(1) << (DATA_W - 1);

    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] bm;
    logic [DATA_W-1:0] top_one;
    logic [DATA_W-1:0] raw;
    logic              b_top;

    always_comb begin
        wmask     = byte_mode ? LOW_MASK : '1;
        top_one   = byte_mode ? BYTE_TOP : WORD_TOP;
        bm        = b & wmask;
        b_top     = byte_mode ? b[HALF_W-1] : b[DATA_W-1];
        opnd_top  = b_top;
        opnd_next = byte_mode ? b[HALF_W-2] : b[DATA_W-2];
        and_zero  = ((a & b & wmask) == '0);
        shift_out = 1'b0;
        unique case (op)
            OP_AND:  raw = a & b;
            OP_OR:   raw = a | b;
            OP_XOR:  raw = a ^ b;
            OP_INC:  raw = b + DATA_W'(1);
            OP_DEC:  raw = b - DATA_W'(1);
            OP_TSET: raw = a | b;
            OP_TCLR: raw = ~a & b;
            OP_SHL: begin
                raw       = bm << 1;
                shift_out = b_top;
            end
            OP_SHR: begin
                raw       = bm >> 1;
                shift_out = bm[0];
            end
            OP_ROL: begin
                raw       = (bm << 1) | {{(DATA_W-1){1'b0}}, cin};
                shift_out = b_top;
            end
            OP_ROR: begin
                raw       = (bm >> 1) | (cin ? top_one : '0);
                shift_out = bm[0];
            end
            default: raw = b;
        endcase
        res = raw & wmask;
    end
endmodule

// File: rtl/dwalu_flagstage.sv
module dwalu_flagstage
    import dwalu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  alu_op_e           op,
    input  logic              imm,
    input  logic              byte_mode,
    input  logic [DATA_W-1:DATA_W/2] acc_hi,
    input  logic [DATA_W-1:0] arith_sum,
    input  logic              arith_cout,
    input  logic              arith_ovf,
    input  logic [DATA_W-1:0] logic_res,
    input  logic              shift_out,
    input  logic              and_zero,
    input  logic              opnd_top,
    input  logic              opnd_next,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output flags_t            fval,
    output flags_t            fmask
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] act;
    logic [DATA_W-1:0] merged;
    logic              act_zero;
    logic              act_sign;
    flags_t            fv_d;
    flags_t            fm_d;

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB, OP_CMP: act = arith_sum;
            default:                act = logic_res;
        endcase
        act_zero = byte_mode ? (act[HALF_W-1:0] == '0) : (act == '0);
        act_sign = byte_mode ? act[HALF_W-1] : act[DATA_W-1];
        merged   = byte_mode ? {acc_hi, act[HALF_W-1:0]} : act;

        fv_d = '{n: act_sign, v: 1'b0, z: act_zero, c: 1'b0};
        unique case (op)
            OP_ADD, OP_SUB:   begin fv_d.v = arith_ovf; fv_d.c = arith_cout; end
            OP_CMP:           fv_d.c = arith_cout;
            OP_SHL, OP_ROL,
            OP_ROR:           fv_d.c = shift_out;
            OP_SHR:           begin fv_d.n = 1'b0; fv_d.c = shift_out; end
            OP_BIT:           fv_d = '{n: opnd_top, v: opnd_next, z: and_zero, c: 1'b0};
            OP_TSET, OP_TCLR: fv_d = '{n: 1'b0, v: 1'b0, z: and_zero, c: 1'b0};
            default:          ;
        endcase
        fm_d = flag_mask(op, imm);
        fv_d = fv_d & fm_d;
    end

    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            out_valid <= 1'b0;
            result    <= '0;
            result_we <= 1'b0;
            fval      <= '0;
            fmask     <= '0;
        end else begin
            out_valid <= 1'b1;
            result    <= merged;
            result_we <= op_writes(op);
            fval      <= fv_d;
            fmask     <= fm_d;
        end
    end
endmodule

// File: rtl/dwalu_top.sv
module dwalu_top
    import dwalu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              emu_bit,
    input  logic              wmode_bit,
    input  logic [3:0]        op,
    input  logic              imm_mode,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic              n_val,
    output logic              n_upd,
    output logic              v_val,
    output logic              v_upd,
    output logic              z_val,
    output logic              z_upd,
    output logic              c_val,
    output logic              c_upd
);
    localparam int HALF_W = DATA_W / 2;

    alu_op_e           op_e;
    logic              byte_mode;
    logic              sub_like;
    logic              add_cin;
    logic [DATA_W-1:0] sum;
    logic              cout;
    logic              ovf;
    logic [DATA_W-1:0] lres;
    logic              sh_out;
    logic              and_zero;
    logic              o_top;
    logic              o_next;
    flags_t            fval;
    flags_t            fmask;

    always_comb begin
        op_e      = alu_op_e'(op);
        byte_mode = width_is_byte(emu_bit, wmode_bit);
        sub_like  = (op_e == OP_SUB) || (op_e == OP_CMP);
        add_cin   = (op_e == OP_CMP) ? 1'b1 : carry_in;
    end

    dwalu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a(acc), .b(opnd), .cin(add_cin), .invert_b(sub_like),
        .byte_mode(byte_mode), .sum(sum), .cout(cout), .ovf(ovf)
    );

    dwalu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op(op_e), .a(acc), .b(opnd), .cin(carry_in), .byte_mode(byte_mode),
        .res(lres), .shift_out(sh_out), .and_zero(and_zero),
        .opnd_top(o_top), .opnd_next(o_next)
    );

    dwalu_flagstage #(.DATA_W(DATA_W)) u_flags (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op_e), .imm(imm_mode),
        .byte_mode(byte_mode), .acc_hi(acc[DATA_W-1:HALF_W]),
        .arith_sum(sum), .arith_cout(cout), .arith_ovf(ovf),
        .logic_res(lres), .shift_out(sh_out), .and_zero(and_zero),
        .opnd_top(o_top), .opnd_next(o_next),
        .out_valid(out_valid), .result(result), .result_we(result_we),
        .fval(fval), .fmask(fmask)
    );

    assign n_val = fval.n;
    assign v_val = fval.v;
    assign z_val = fval.z;
    assign c_val = fval.c;
    assign n_upd = fmask.n;
    assign v_upd = fmask.v;
    assign z_upd = fmask.z;
    assign c_upd = fmask.c;

    assert_byte_keeps_high_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (emu_bit || wmode_bit)) |=> (result[DATA_W-1:HALF_W] == $past(acc[DATA_W-1:HALF_W])));

    assert_add_all_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_e == OP_ADD) |=> (n_upd && v_upd && z_upd && c_upd && result_we));

    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_e == OP_CMP) |=> (!result_we && !v_upd && c_upd && n_upd && z_upd));

    assert_shr_clears_sign_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_e == OP_SHR) |=> (n_upd && !n_val));

    assert_bit_imm_z_only_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_e == OP_BIT && imm_mode) |=> (z_upd && !n_upd && !v_upd && !c_upd && !result_we));

    assert_bit_word_sign_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_e == OP_BIT && !imm_mode && !emu_bit && !wmode_bit)
        |=> (n_val == $past(opnd[DATA_W-1]) && v_val == $past(opnd[DATA_W-2])));

    assert_test_ops_z_only_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_e == OP_TSET || op_e == OP_TCLR)) |=> (z_upd && !n_upd && !v_upd && !c_upd && result_we));

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !result_we && !n_upd && !v_upd && !z_upd && !c_upd));
endmodule

// File: tb/dwalu_top_tb_top.sv
`timescale 1ns/1ps
module dwalu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        emu_bit = 1'b0;
    logic        wmode_bit = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        imm_mode = 1'b0;
    logic [15:0] acc = 16'h0;
    logic [15:0] opnd = 16'h0;
    logic        carry_in = 1'b0;
    logic        out_valid, result_we;
    logic [15:0] result;
    logic        n_val, n_upd, v_val, v_upd, z_val, z_upd, c_val, c_upd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dwalu_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .emu_bit(emu_bit), .wmode_bit(wmode_bit),
        .op(op), .imm_mode(imm_mode), .acc(acc), .opnd(opnd), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .result_we(result_we),
        .n_val(n_val), .n_upd(n_upd), .v_val(v_val), .v_upd(v_upd),
        .z_val(z_val), .z_upd(z_upd), .c_val(c_val), .c_upd(c_upd)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive one request and compare every output with an independent model
    task automatic run(input string tag, input logic [3:0] o, input logic e, input logic w,
                       input logic im, input logic [15:0] a, input logic [15:0] b, input logic ci);
        int wd, mask, av, bv, s, r, tb_, xr;
        int en, em, ev, ez, ec, mn, mv, mz, mc, we, exp_res;
        @(negedge clk);
        op = o; emu_bit = e; wmode_bit = w; imm_mode = im; acc = a; opnd = b; carry_in = ci;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        wd   = (e || w) ? 8 : 16;
        mask = (1 << wd) - 1;
        tb_  = 1 << (wd - 1);
        av = int'(a) & mask; bv = int'(b) & mask;
        en = 0; ev = 0; ez = 0; ec = 0; mn = 0; mv = 0; mz = 0; mc = 0; we = 1; r = 0;
        case (o)
            4'd0, 4'd1, 4'd5: begin
                xr = (o == 4'd0) ? bv : (~bv & mask);
                s  = av + xr + ((o == 4'd5) ? 1 : int'(ci));
                r  = s & mask;
                ec = (s >> wd) & 1;
                ev = (((av ^ r) & (xr ^ r) & tb_) != 0) ? 1 : 0;
                mn = 1; mz = 1; mc = 1; mv = (o != 4'd5) ? 1 : 0;
                if (o == 4'd5) begin we = 0; ec = (av >= bv) ? 1 : 0; end
            end
            4'd2: begin r = av & bv; mn = 1; mz = 1; end
            4'd3: begin r = av | bv; mn = 1; mz = 1; end
            4'd4: begin r = av ^ bv; mn = 1; mz = 1; end
            4'd11: begin r = (bv + 1) & mask; mn = 1; mz = 1; end
            4'd12: begin r = (bv - 1) & mask; mn = 1; mz = 1; end
            4'd15: begin r = bv; mn = 1; mz = 1; end
            4'd7: begin r = (bv << 1) & mask; ec = ((bv & tb_) != 0) ? 1 : 0; mn = 1; mz = 1; mc = 1; end
            4'd8: begin r = bv >> 1; ec = bv & 1; mn = 1; mz = 1; mc = 1; end
            4'd9: begin r = ((bv << 1) | int'(ci)) & mask; ec = ((bv & tb_) != 0) ? 1 : 0; mn = 1; mz = 1; mc = 1; end
            4'd10: begin r = (bv >> 1) | (ci ? tb_ : 0); ec = bv & 1; mn = 1; mz = 1; mc = 1; end
            4'd6: begin
                we = 0; mz = 1; ez = ((av & bv) == 0) ? 1 : 0;
                if (!im) begin
                    mn = 1; mv = 1;
                    en = ((bv & tb_) != 0) ? 1 : 0;
                    ev = ((bv & (tb_ >> 1)) != 0) ? 1 : 0;
                end
            end
            4'd13, 4'd14: begin
                r = (o == 4'd13) ? (av | bv) : (~av & bv & mask);
                mz = 1; ez = ((av & bv) == 0) ? 1 : 0;
            end
            default: ;
        endcase
        if (o != 4'd6 && o != 4'd13 && o != 4'd14) begin
            en = ((r & tb_) != 0) ? 1 : 0;
            ez = (r == 0) ? 1 : 0;
        end
        if (o == 4'd8) en = 0;
        exp_res = (wd == 8) ? ((int'(a) & 'hFF00) | r) : r;
        chk({tag, " out_valid"}, int'(out_valid), 1);
        chk({tag, " we"}, int'(result_we), we);
        if (we != 0) chk({tag, " result"}, int'(result), exp_res);
        chk({tag, " masks"}, int'({n_upd, v_upd, z_upd, c_upd}), (mn << 3) | (mv << 2) | (mz << 1) | mc);
        if (mn != 0) chk({tag, " N"}, int'(n_val), en);
        if (mv != 0) chk({tag, " V"}, int'(v_val), ev);
        if (mz != 0) chk({tag, " Z"}, int'(z_val), ez);
        if (mc != 0) chk({tag, " C"}, int'(c_val), ec);
    endtask

    task automatic test_reset_R13();
        rst = 1'b1; in_valid = 1'b1; op = 4'd0;
        repeat (3) @(negedge clk);
        chk("R13 reset out_valid", int'(out_valid), 0);
        chk("R13 reset masks", int'({n_upd, v_upd, z_upd, c_upd, result_we}), 0);
        in_valid = 1'b0; rst = 1'b0;
        @(negedge clk);
        chk("R13 idle out_valid", int'(out_valid), 0);
        chk("R13 idle masks", int'({n_upd, v_upd, z_upd, c_upd, result_we}), 0);
    endtask

    task automatic test_add_R3();
        run("R3 byte 7F+01", 4'd0, 1, 0, 0, 16'hAB7F, 16'h0001, 0);
        chk("R3 byte 7F+01 value", int'(result), 'hAB80);
        chk("R3 byte 7F+01 NV", int'({n_val, v_val, c_val}), 3'b110);
        run("R3 byte FF+01 c1", 4'd0, 0, 1, 0, 16'h12FF, 16'h0001, 1);
        chk("R3 byte FF+01+1 value", int'(result), 'h1201);
        chk("R3 byte carry", int'(c_val), 1);
        run("R3 word 7FFF+1", 4'd0, 0, 0, 0, 16'h7FFF, 16'h0001, 0);
        chk("R3 word overflow", int'({v_val, n_val}), 2'b11);
    endtask

    task automatic test_width_R1();
        run("R1 emu byte", 4'd0, 1, 0, 0, 16'h00FF, 16'h0001, 0);
        chk("R1 emu byte value", int'(result), 'h0000);
        chk("R1 emu byte C", int'(c_val), 1);
        run("R1 mode byte", 4'd0, 0, 1, 0, 16'h00FF, 16'h0001, 0);
        chk("R1 mode byte C", int'(c_val), 1);
        run("R1 word", 4'd0, 0, 0, 0, 16'h00FF, 16'h0001, 0);
        chk("R1 word value", int'(result), 'h0100);
        chk("R1 word C", int'(c_val), 0);
        run("R2 emu+mode byte", 4'd7, 1, 1, 0, 16'hC3A5, 16'h0081, 0);
        chk("R2 high byte kept", int'(result[15:8]), 'hC3);
    endtask

    task automatic test_sub_cmp_R4_R5();
        run("R4 byte 05-03 c1", 4'd1, 1, 0, 0, 16'h0005, 16'h0003, 1);
        chk("R4 value", int'(result[7:0]), 'h02);
        chk("R4 no borrow C", int'(c_val), 1);
        run("R4 byte 03-05 c1", 4'd1, 1, 0, 0, 16'h0003, 16'h0005, 1);
        chk("R4 borrow C", int'(c_val), 0);
        run("R4 word 8000-1 c0", 4'd1, 0, 0, 0, 16'h8000, 16'h0001, 0);
        chk("R4 word overflow", int'({result, v_val}), {16'h7FFE, 1'b1});
        run("R5 cmp equal", 4'd5, 0, 0, 0, 16'h1234, 16'h1234, 0);
        chk("R5 equal ZC", int'({z_val, c_val, result_we}), 3'b110);
        run("R5 cmp less", 4'd5, 1, 0, 0, 16'h0010, 16'h0020, 1);
        chk("R5 less C", int'(c_val), 0);
    endtask

    task automatic test_logic_R6();
        run("R6 and", 4'd2, 0, 0, 0, 16'hF0F0, 16'h0FF0, 0);
        run("R6 or",  4'd3, 1, 0, 0, 16'h5500, 16'h0080, 1);
        run("R6 xor zero", 4'd4, 0, 1, 0, 16'h3C3C, 16'h003C, 0);
        run("R6 inc wrap", 4'd11, 1, 0, 0, 16'h7700, 16'h00FF, 0);
        chk("R6 inc wrap value", int'(result), 'h7700);
        run("R6 dec word", 4'd12, 0, 0, 0, 16'h0000, 16'h0000, 0);
        chk("R6 dec word value", int'(result), 'hFFFF);
        run("R6 pass", 4'd15, 0, 0, 0, 16'h0000, 16'h8001, 1);
    endtask

    task automatic test_shift_R7_R8_R9();
        run("R7 shl byte", 4'd7, 1, 0, 0, 16'h0000, 16'h00C1, 0);
        run("R7 shl word", 4'd7, 0, 0, 0, 16'h0000, 16'h8001, 1);
        run("R8 shr byte", 4'd8, 0, 1, 0, 16'h0000, 16'h0081, 1);
        chk("R8 shr value", int'({result[7:0], n_val, c_val}), {8'h40, 1'b0, 1'b1});
        run("R8 shr word", 4'd8, 0, 0, 0, 16'h0000, 16'hFFFE, 0);
        run("R9 rol byte", 4'd9, 1, 0, 0, 16'h0000, 16'h0080, 1);
        chk("R9 rol value", int'({result[7:0], c_val}), {8'h01, 1'b1});
        run("R9 ror word", 4'd10, 0, 0, 0, 16'h0000, 16'h0001, 1);
        chk("R9 ror value", int'({result, c_val}), {16'h8000, 1'b1});
        run("R9 ror byte", 4'd10, 1, 1, 0, 16'h0000, 16'h0002, 1);
        chk("R9 ror byte value", int'(result[7:0]), 'h81);
    endtask

    task automatic test_bit_R10_R11();
        run("R10 bit imm", 4'd6, 1, 0, 1, 16'h000F, 16'h00F0, 0);
        chk("R10 imm z", int'({z_val, n_upd, v_upd}), 3'b100);
        run("R11 bit byte", 4'd6, 1, 0, 0, 16'h0001, 16'h00C1, 0);
        chk("R11 byte NVZ", int'({n_val, v_val, z_val}), 3'b110);
        run("R11 bit word", 4'd6, 0, 0, 0, 16'h0000, 16'h4000, 0);
        chk("R11 word NVZ", int'({n_val, v_val, z_val}), 3'b011);
    endtask

    task automatic test_tst_R12();
        run("R12 tset", 4'd13, 0, 0, 0, 16'h0F00, 16'h00F0, 0);
        chk("R12 tset value", int'({result, z_val}), {16'h0FF0, 1'b1});
        run("R12 tclr", 4'd14, 1, 0, 0, 16'hFF0C, 16'h003F, 0);
        chk("R12 tclr value", int'({result, z_val}), {16'hFF33, 1'b0});
    endtask

    task automatic test_sweep_R3_R6();
        logic [15:0] x;
        x = 16'hACE1;
        for (int i = 0; i < 160; i++) begin
            x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
            run("R3 R6 sweep", x[3:0], x[4], x[5], x[6], x ^ 16'h5A5A, {x[7:0], x[15:8]}, x[7]);
        end
    endtask

    task automatic test_idle_R13();
        run("R13 before idle", 4'd2, 0, 0, 0, 16'h1111, 16'h1111, 0);
        @(negedge clk);
        chk("R13 idle after request", int'({out_valid, result_we, n_upd, z_upd}), 0);
    endtask

    initial begin
        test_reset_R13();
        test_add_R3();
        test_width_R1();
        test_sub_cmp_R4_R5();
        test_logic_R6();
        test_shift_R7_R8_R9();
        test_bit_R10_R11();
        test_tst_R12();
        test_sweep_R3_R6();
        test_idle_R13();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule